// File: doc/BRIEF.md
# Multi-Channel Capture/Compare Timer

This block is a 16-bit timer with a small set of capture/compare channels. The channel count is a parameter from 2 to 5. A word-wide register bus reaches a control register, the counter, one control and one value register per channel, and an interrupt vector register. The counter has four modes. It can halt, count up to the channel-0 value and wrap, run freely through the full range, or count up to the channel-0 value and back down to zero. It advances on one of four tick inputs, and a divider of 1, 2, 4 or 8 sits between the tick and the counter.

Each channel works in one of two ways. In capture mode it copies the counter when its selected input shows a chosen edge. In compare mode it raises its flag when the counter steps onto the channel value. Flags from channels 1 and up, together with the counter wrap flag, feed a prioritised vector. Reading the vector returns the most urgent event and clears that flag. Channel 0 keeps a flag and an output of its own, and it also sets the wrap limit in the up and up/down modes.

Top module: `mcct_timer`

## Requirements
- R1: After reset every register reads zero, the vector reads 0x0000 and `irq_pend` and `ch0_flag` are low.
- R2: In halt mode (control bits 5:4 = 0) ticks do not move the counter, and a bus write to offset 0x10 loads it.
- R3: In free mode (mode 2) the counter steps by one per divided tick and goes from 0xFFFF to 0x0000. That step sets the wrap flag, control bit 0.
- R4: In up mode (mode 1) the counter climbs to the channel-0 value. The next step returns it to zero and sets the wrap flag.
- R5: In up/down mode (mode 3) the counter climbs to the channel-0 value and then descends. It sets the wrap flag on arriving at zero and then climbs again.
- R6: The divider field, control bits 7:6 = d, advances the counter once every 2^d selected ticks. A control write restarts the divider.
- R7: The source field, control bits 9:8 = s, selects `tick_src[s]`. Pulses on the other tick inputs do nothing.
- R8: A channel in compare mode (channel-control bit 8 = 0) sets its flag, bit 0, when the counter steps onto the channel value.
- R9: A channel in capture mode (bit 8 = 1) takes its edge choice from bits 15:14: 0 none, 1 rising, 2 falling, 3 both. On a matching edge it copies the counter into its value register and sets its flag.
- R10: Input select, bits 13:12, picks 0 = `cap_a`, 1 = `cap_b`, 2 = constant low, 3 = constant high. A non-selected input and the constant choices never capture.
- R11: A capture that arrives while the channel flag is still set also sets the overrun bit, channel-control bit 1.
- R12: The vector at 0x2E reads 2·i for the lowest-numbered flagged channel i ≥ 1, otherwise 0x000E if the wrap flag is set, otherwise 0x0000. The read clears only the flag it reports, and channel 0 never appears. `irq_pend` is high while any reported flag is set.
- R13: Channel control sits at 0x02+2i, channel value at 0x12+2i. Reads of unmapped offsets, including channels at or above the channel count, return zero. Read data appears one cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the word register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| tick_src | input | 4 | Four counting enable pulses |
| cap_a | input | NCH | First capture input per channel |
| cap_b | input | NCH | Second capture input per channel |
| ch0_flag | output | 1 | Channel-0 event flag |
| irq_pend | output | 1 | Any vector-reported flag set |

## Verification
A stale up/down direction bit or a divider that has slipped out of phase shows up as a wrong count on the counter read that follows within at most eight ticks. A lost or spurious flag changes `irq_pend` in the next cycle and makes the following vector read differ from the expected code. A wrong capture edge, source or overrun shows up in the channel value and control reads straight after the edge. The random passes vary the divider, the source, the loaded count and the flag pattern, so an error that depends on a particular value cannot hide behind one fixed case.

// File: rtl/mcct_pkg.sv
package mcct_pkg;
  typedef enum logic [1:0] {
    MODE_HALT = 2'd0,
    MODE_UP   = 2'd1,
    MODE_FREE = 2'd2,
    MODE_UPDN = 2'd3
  } cnt_mode_e;

  localparam logic [5:0] ADR_CTRL  = 6'h00;
  localparam logic [5:0] ADR_CHCTL = 6'h02;
  localparam logic [5:0] ADR_COUNT = 6'h10;
  localparam logic [5:0] ADR_CHVAL = 6'h12;
  localparam logic [5:0] ADR_VEC   = 6'h2E;

  localparam int          PSC_W   = 3;
  localparam int          NSRC    = 4;
  localparam logic [15:0] VEC_OVF = 16'h000E;
endpackage

// File: rtl/mcct_prescale.sv
module mcct_prescale
  import mcct_pkg::*;
#(
  parameter int SRCS  = NSRC,
  parameter int DIV_W = PSC_W,
  localparam int SW   = $clog2(SRCS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SRCS-1:0] tick_src,
  input  logic [SW-1:0]   src_sel,
  input  logic [1:0]      div_sel,
  input  logic            restart,
  output logic            adv
);
  logic [DIV_W-1:0] pcnt_q;
  logic [DIV_W-1:0] lim;
  logic             tick;

  always_comb begin
    lim  = DIV_W'((32'd1 << div_sel) - 32'd1);
    tick = tick_src[src_sel];
    adv  = tick && (pcnt_q >= lim);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pcnt_q <= '0;
    end else if (tick) begin
      if (pcnt_q >= lim) pcnt_q <= '0;
      else               pcnt_q <= pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mcct_counter.sv
module mcct_counter
  import mcct_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  cnt_mode_e     mode,
  input  logic [CW-1:0] top_val,
  input  logic          adv,
  input  logic          wr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nx,
  output logic          step,
  output logic          wrap
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic down_q, down_nx, wrap_c;

  always_comb begin
    cnt_nx  = cnt;
    down_nx = down_q;
    wrap_c  = 1'b0;
    unique case (mode)
      MODE_HALT: cnt_nx = cnt;
      MODE_UP: begin
        if (cnt >= top_val) begin
          cnt_nx = '0;
          wrap_c = 1'b1;
        end else begin
          cnt_nx = cnt + ONE;
        end
      end
      MODE_FREE: begin
        cnt_nx = cnt + ONE;
        wrap_c = &cnt;
      end
      MODE_UPDN: begin
        if (down_q) begin
          if (cnt <= ONE) begin
            cnt_nx  = '0;
            wrap_c  = 1'b1;
            down_nx = 1'b0;
          end else begin
            cnt_nx = cnt - ONE;
          end
        end else if (cnt >= top_val && cnt != '0) begin
          cnt_nx = cnt - ONE;
          if (cnt == ONE) wrap_c  = 1'b1;
          else            down_nx = 1'b1;
        end else begin
          cnt_nx = cnt + ONE;
        end
      end
      default: cnt_nx = cnt;
    endcase
    step = adv && !wr && (mode != MODE_HALT);
    wrap = step && wrap_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      down_q <= 1'b0;
    end else begin
      if (wr)        cnt <= wdata;
      else if (step) cnt <= cnt_nx;
      if (mode != MODE_UPDN) down_q <= 1'b0;
      else if (step)         down_q <= down_nx;
    end
  end
endmodule

// File: rtl/mcct_channel.sv
module mcct_channel #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic          val_we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] cnt,
  input  logic [DW-1:0] cnt_nx,
  input  logic          step,
  input  logic          in_a,
  input  logic          in_b,
  input  logic          clr,
  output logic [DW-1:0] ctl_rd,
  output logic [DW-1:0] val_rd,
  output logic          flag
);
  logic [1:0]    edge_q, insel_q, insel_d;
  logic          capen_q, ovr_q, prev_q, in_now;
  logic          rise, fall, cap_hit, cmp_hit, flag_nx;
  logic [DW-1:0] val_q;

  function automatic logic pick(input logic [1:0] s, input logic a, input logic b);
    case (s)
      2'd0:    return a;
      2'd1:    return b;
      2'd2:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  always_comb begin
    insel_d = ctl_we ? wdata[13:12] : insel_q;
    in_now  = pick(insel_q, in_a, in_b);
    rise    = in_now && !prev_q;
    fall    = !in_now && prev_q;
    cap_hit = capen_q && ((edge_q[0] && rise) || (edge_q[1] && fall));
    cmp_hit = !capen_q && step && (cnt_nx == val_q);
    flag_nx = flag_q_sel();
  end

  function automatic logic flag_q_sel();
    logic f;
    f = flag;
    if (ctl_we) f = wdata[0];
    if (clr) f = 1'b0;
    if (cap_hit || cmp_hit) f = 1'b1;
    return f;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_q  <= '0;
      insel_q <= '0;
      capen_q <= 1'b0;
      ovr_q   <= 1'b0;
      flag    <= 1'b0;
      prev_q  <= 1'b0;
      val_q   <= '0;
    end else begin
      prev_q <= pick(insel_d, in_a, in_b);
      flag   <= flag_nx;
      if (ctl_we) begin
        edge_q  <= wdata[15:14];
        insel_q <= wdata[13:12];
        capen_q <= wdata[8];
        ovr_q   <= wdata[1];
      end
      if (cap_hit && flag) ovr_q <= 1'b1;
      if (cap_hit)     val_q <= cnt;
      else if (val_we) val_q <= wdata;
    end
  end

  assign ctl_rd = DW'({edge_q, insel_q, 3'b000, capen_q, 6'b000000, ovr_q, flag});
  assign val_rd = val_q;
endmodule

// File: rtl/mcct_timer.sv
module mcct_timer
  import mcct_pkg::*;
#(
  parameter int NCH = 3,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [5:0]     bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [3:0]     tick_src,
  input  logic [NCH-1:0] cap_a,
  input  logic [NCH-1:0] cap_b,
  output logic           ch0_flag,
  output logic           irq_pend
);
  cnt_mode_e     mode_q;
  logic [1:0]    div_q, src_q;
  logic          ovf_q, ovf_clr;
  logic          ctrl_we, cnt_we, vec_rd, adv, step, wrap;
  logic [DW-1:0] cnt_q, cnt_nx, ctrl_rd, vec_code, rd_mux;
  logic [NCH-1:0] flags, ch_clr, chctl_we, chval_we;
  logic [DW-1:0] ch_ctl [NCH];
  logic [DW-1:0] ch_val [NCH];

  assign ctrl_we = bus_sel && bus_wr && (bus_addr == ADR_CTRL);
  assign cnt_we  = bus_sel && bus_wr && (bus_addr == ADR_COUNT);
  assign vec_rd  = bus_sel && !bus_wr && (bus_addr == ADR_VEC);

  mcct_prescale #(.SRCS(NSRC), .DIV_W(PSC_W)) psc_i (
    .clk(clk), .rst(rst), .tick_src(tick_src), .src_sel(src_q),
    .div_sel(div_q), .restart(ctrl_we), .adv(adv)
  );

  mcct_counter #(.CW(DW)) cnt_i (
    .clk(clk), .rst(rst), .mode(mode_q), .top_val(ch_val[0]), .adv(adv),
    .wr(cnt_we), .wdata(bus_wdata), .cnt(cnt_q), .cnt_nx(cnt_nx),
    .step(step), .wrap(wrap)
  );

  // lowest-numbered channel wins; wrap flag only when no channel is pending
  always_comb begin
    vec_code = ovf_q ? VEC_OVF : '0;
    for (int i = NCH - 1; i >= 1; i--) begin
      if (flags[i]) vec_code = DW'(2 * i);
    end
    ovf_clr = vec_rd && (vec_code == VEC_OVF);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam logic [5:0] CTL_A = ADR_CHCTL + 6'(2 * g);
    localparam logic [5:0] VAL_A = ADR_CHVAL + 6'(2 * g);
    assign chctl_we[g] = bus_sel && bus_wr && (bus_addr == CTL_A);
    assign chval_we[g] = bus_sel && bus_wr && (bus_addr == VAL_A);
    if (g == 0) begin : g_own
      assign ch_clr[g] = 1'b0;
    end else begin : g_shared
      assign ch_clr[g] = vec_rd && (vec_code == DW'(2 * g));
    end
    mcct_channel #(.DW(DW)) ch_i (
      .clk(clk), .rst(rst), .ctl_we(chctl_we[g]), .val_we(chval_we[g]),
      .wdata(bus_wdata), .cnt(cnt_q), .cnt_nx(cnt_nx), .step(step),
      .in_a(cap_a[g]), .in_b(cap_b[g]), .clr(ch_clr[g]),
      .ctl_rd(ch_ctl[g]), .val_rd(ch_val[g]), .flag(flags[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_HALT;
      div_q  <= '0;
      src_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (ctrl_we) begin
        mode_q <= cnt_mode_e'(bus_wdata[5:4]);
        div_q  <= bus_wdata[7:6];
        src_q  <= bus_wdata[9:8];
      end
      if (wrap)         ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
      else if (ctrl_we) ovf_q <= bus_wdata[0];
    end
  end

  assign ctrl_rd = DW'({src_q, div_q, mode_q, 3'b000, ovf_q});

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADR_CTRL)  rd_mux = ctrl_rd;
    if (bus_addr == ADR_COUNT) rd_mux = cnt_q;
    if (bus_addr == ADR_VEC)   rd_mux = vec_code;
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ADR_CHCTL + 6'(2 * i)) rd_mux = ch_ctl[i];
      if (bus_addr == ADR_CHVAL + 6'(2 * i)) rd_mux = ch_val[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
  end

  assign ch0_flag = flags[0];
  assign irq_pend = ovf_q || (|flags[NCH-1:1]);
endmodule

// File: rtl/mcct_timer_chk.sv
module mcct_timer_chk #(
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     mode,
  input logic [1:0]     src,
  input logic [3:0]     tick_src,
  input logic           adv,
  input logic           step,
  input logic [15:0]    cnt,
  input logic [15:0]    cmp0,
  input logic           cnt_wr,
  input logic           ovf,
  input logic [NCH-1:0] flags,
  input logic [15:0]    vec,
  input logic           pend
);
  // R2
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && !cnt_wr) |=> $stable(cnt));

  // R7
  tick_src_chk: assert property (@(posedge clk) disable iff (rst)
    adv |-> tick_src[src]);

  // R3
  free_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd2 && step && cnt == 16'hFFFF) |=> (cnt == 16'h0000 && ovf));

  // R4
  up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && step && cnt >= cmp0) |=> (cnt == 16'h0000 && ovf));

  // R12
  vec_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && flags[NCH-1:1] == '0) |-> (vec == 16'h000E && pend));

  // R12
  vec_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!ovf && flags[NCH-1:1] == '0) |-> (vec == 16'h0000 && !pend));
endmodule

bind mcct_timer mcct_timer_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rst(rst), .mode(mode_q), .src(src_q), .tick_src(tick_src),
  .adv(adv), .step(step), .cnt(cnt_q), .cmp0(ch_val[0]), .cnt_wr(cnt_we),
  .ovf(ovf_q), .flags(flags), .vec(vec_code), .pend(irq_pend)
);

// File: tb/mcct_timer_tb_top.sv
`timescale 1ns/1ps
module mcct_timer_tb_top;
  localparam int NCH = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]     bus_addr = '0;
  logic [15:0]    bus_wdata = '0;
  logic [15:0]    bus_rdata;
  logic [3:0]     tick_src = '0;
  logic [NCH-1:0] cap_a = '0, cap_b = '0;
  logic           ch0_flag, irq_pend;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mcct_timer #(.NCH(NCH), .DW(16)) dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_src(tick_src), .cap_a(cap_a), .cap_b(cap_b),
    .ch0_flag(ch0_flag), .irq_pend(irq_pend)
  );

  function automatic logic [15:0] exp_ctrl(input int mode, input int div, input int src, input bit ovf);
    return 16'((src << 8) | (div << 6) | (mode << 4) | int'(ovf));
  endfunction

  function automatic logic [15:0] exp_vec(input bit ovf, input bit f1, input bit f2);
    if (f1) return 16'h0002;
    if (f2) return 16'h0004;
    if (ovf) return 16'h000E;
    return 16'h0000;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata; bus_sel = 0;
  endtask

  task automatic rchk(input string tag, input logic [5:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse(input int s, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_src[s] = 1'b1;
      @(negedge clk); tick_src = '0;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd4417));
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rchk("R1 ctrl", 6'h00, 16'h0000);
    rchk("R1 count", 6'h10, 16'h0000);
    rchk("R1 vec", 6'h2E, 16'h0000);
    rchk("R1 chctl1", 6'h04, 16'h0000);
    rchk("R1 val2", 6'h16, 16'h0000);
    chk("R1 pend", 16'(irq_pend), 16'h0000);
    wr(6'h04, 16'h0100);
    wr(6'h06, 16'h0100);
    // R2 halt ignores ticks, write loads
    wr(6'h10, 16'h1234);
    pulse(0, 5);
    rchk("R2 halt", 6'h10, 16'h1234);
    // R3 free run wrap
    wr(6'h10, 16'hFFFD);
    wr(6'h00, exp_ctrl(2, 0, 0, 0));
    pulse(0, 2);
    rchk("R3 cnt", 6'h10, 16'hFFFF);
    rchk("R3 noflag", 6'h00, exp_ctrl(2, 0, 0, 0));
    pulse(0, 1);
    rchk("R3 wrap", 6'h10, 16'h0000);
    rchk("R3 flag", 6'h00, exp_ctrl(2, 0, 0, 1));
    chk("R8 ch0 own flag", 16'(ch0_flag), 16'h0001);
    rchk("R12 ovf code", 6'h2E, 16'h000E);
    rchk("R12 ch0 excluded", 6'h2E, 16'h0000);
    chk("R12 ch0 kept", 16'(ch0_flag), 16'h0001);
    // R7 source select
    wr(6'h00, exp_ctrl(2, 0, 2, 0));
    wr(6'h10, 16'h0000);
    pulse(0, 4); pulse(1, 3); pulse(3, 2);
    rchk("R7 other src", 6'h10, 16'h0000);
    pulse(2, 3);
    rchk("R7 chosen src", 6'h10, 16'h0003);
    // R6 random divider and source
    for (int k = 0; k < 6; k++) begin
      int d, s, n;
      d = int'($urandom % 4); s = int'($urandom % 4); n = int'($urandom % 20);
      wr(6'h00, exp_ctrl(2, d, s, 0));
      wr(6'h10, 16'h0000);
      pulse(s, n);
      rchk("R6 divide", 6'h10, 16'(n >> d));
    end
    // R4 up mode
    wr(6'h00, 16'h0000);
    wr(6'h12, 16'h0005);
    wr(6'h10, 16'h0000);
    wr(6'h02, 16'h0000);
    wr(6'h00, exp_ctrl(1, 0, 0, 0));
    pulse(0, 5);
    rchk("R4 top", 6'h10, 16'h0005);
    rchk("R4 noflag", 6'h00, exp_ctrl(1, 0, 0, 0));
    rchk("R8 ch0 compare", 6'h02, 16'h0001);
    pulse(0, 1);
    rchk("R4 wrap", 6'h10, 16'h0000);
    rchk("R4 flag", 6'h00, exp_ctrl(1, 0, 0, 1));
    // R5 up/down
    wr(6'h00, 16'h0000);
    wr(6'h12, 16'h0003);
    wr(6'h10, 16'h0000);
    wr(6'h00, exp_ctrl(3, 0, 0, 0));
    pulse(0, 3);
    rchk("R5 peak", 6'h10, 16'h0003);
    pulse(0, 1);
    rchk("R5 descend", 6'h10, 16'h0002);
    rchk("R5 noflag", 6'h00, exp_ctrl(3, 0, 0, 0));
    pulse(0, 2);
    rchk("R5 zero", 6'h10, 16'h0000);
    rchk("R5 flag", 6'h00, exp_ctrl(3, 0, 0, 1));
    pulse(0, 1);
    rchk("R5 climb", 6'h10, 16'h0001);
    // R9 / R11 capture on channel 1, input A, rising edge
    wr(6'h00, 16'h0000);
    wr(6'h10, 16'h0ABC);
    wr(6'h04, 16'h4100);
    @(negedge clk); cap_a[1] = 1'b1;
    rchk("R9 rise value", 6'h14, 16'h0ABC);
    rchk("R9 rise flag", 6'h04, 16'h4101);
    wr(6'h10, 16'h0111);
    @(negedge clk); cap_a[1] = 1'b0;
    rchk("R9 fall ignored", 6'h14, 16'h0ABC);
    @(negedge clk); cap_a[1] = 1'b1;
    rchk("R11 value", 6'h14, 16'h0111);
    rchk("R11 overrun", 6'h04, 16'h4103);
    @(negedge clk); cap_a[1] = 1'b0;
    @(negedge clk); cap_a[2] = 1'b1;
    @(negedge clk); cap_a[2] = 1'b0;
    rchk("R9 edge none", 6'h16, 16'h0000);
    // R10 input B with both edges, then constants
    wr(6'h06, 16'hD100);
    wr(6'h10, 16'h0200);
    @(negedge clk); cap_a[2] = 1'b1;
    rchk("R10 A unselected", 6'h16, 16'h0000);
    @(negedge clk); cap_b[2] = 1'b1;
    rchk("R10 B rise", 6'h16, 16'h0200);
    wr(6'h10, 16'h0201);
    @(negedge clk); cap_b[2] = 1'b0;
    rchk("R9 both fall", 6'h16, 16'h0201);
    rchk("R11 both overrun", 6'h06, 16'hD103);
    wr(6'h06, 16'hF100);
    wr(6'h10, 16'h0300);
    @(negedge clk); cap_b[2] = 1'b1; cap_a[2] = 1'b0;
    @(negedge clk); cap_b[2] = 1'b0; cap_a[2] = 1'b1;
    rchk("R10 supply", 6'h16, 16'h0201);
    rchk("R10 supply ctl", 6'h06, 16'hF100);
    wr(6'h06, 16'hE100);
    @(negedge clk); cap_b[2] = 1'b1; cap_a[2] = 1'b0;
    @(negedge clk); cap_b[2] = 1'b0;
    rchk("R10 ground", 6'h16, 16'h0201);
    // R12 directed priority walk
    wr(6'h00, 16'h0001);
    wr(6'h04, 16'h0101);
    wr(6'h06, 16'h0101);
    chk("R12 pend high", 16'(irq_pend), 16'h0001);
    rchk("R12 ch1 first", 6'h2E, 16'h0002);
    rchk("R12 ch1 cleared", 6'h04, 16'h0100);
    rchk("R12 ch2 next", 6'h2E, 16'h0004);
    rchk("R12 ovf last", 6'h2E, 16'h000E);
    rchk("R12 ovf cleared", 6'h00, 16'h0000);
    rchk("R12 empty", 6'h2E, 16'h0000);
    chk("R12 pend low", 16'(irq_pend), 16'h0000);
    // R12 random flag patterns
    for (int k = 0; k < 8; k++) begin
      bit o, f1, f2;
      logic [15:0] e;
      o = 1'($urandom); f1 = 1'($urandom); f2 = 1'($urandom);
      wr(6'h00, 16'(o));
      wr(6'h04, 16'h0100 | 16'(f1));
      wr(6'h06, 16'h0100 | 16'(f2));
      for (int j = 0; j < 4; j++) begin
        e = exp_vec(o, f1, f2);
        rchk("R12 random vec", 6'h2E, e);
        if (e == 16'h0002) f1 = 0;
        else if (e == 16'h0004) f2 = 0;
        else if (e == 16'h000E) o = 0;
      end
    end
    // R8 compare on channel 2
    wr(6'h06, 16'h0000);
    wr(6'h16, 16'h0007);
    wr(6'h10, 16'h0005);
    wr(6'h00, exp_ctrl(2, 0, 0, 0));
    pulse(0, 1);
    rchk("R8 before match", 6'h06, 16'h0000);
    pulse(0, 1);
    rchk("R8 match", 6'h06, 16'h0001);
    // R13 unmapped offsets
    rchk("R13 unmapped", 6'h20, 16'h0000);
    rchk("R13 absent channel", 6'h0A, 16'h0000);
    // R9 random capture values
    wr(6'h00, 16'h0000);
    for (int k = 0; k < 16; k++) begin
      logic [15:0] v;
      v = 16'($urandom);
      wr(6'h10, v);
      wr(6'h04, 16'h4100);
      @(negedge clk); cap_a[1] = 1'b1;
      @(negedge clk); cap_a[1] = 1'b0;
      rchk("R9 random capture", 6'h14, v);
      rchk("R9 random flag", 6'h04, 16'h4101);
    end
    summary();
  end
endmodule